// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the memory side of a single data rate SDRAM command bus. On every rising clock it samples the chip select, row strobe, column strobe, write enable and clock enable pins, along with the bank select and the address. It turns them into one command code. It tracks, for each of four banks, whether a row is open and which row it is. It also holds the mode word that the controller loaded. Commands that break the bank or mode rules are flagged and dropped. The decoded command comes out one clock later with its bank, row, column and auto-precharge fields.

The block also has a mask path for the data byte lanes. For reads, the mask that reaches the data lanes is the mask sampled two edges earlier. For writes, the mask is passed through in the same cycle. The block is meant to be used as a protocol monitor, or as the front end of a memory model that keeps its own storage.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When `cs_n` is high, the command is inhibit (code 0), whatever the other pins are. It raises no error and changes no state.
- R2: With `cs_n` low, the strobes {ras_n,cas_n,we_n} decode as follows: 111 to NOP (1), 011 to ACTIVE (2), 101 to READ (3), 100 to WRITE (4), 110 to BURST STOP (5), 010 to PRECHARGE (6), 000 to MODE LOAD (9). Pattern 001 is AUTO REFRESH (7) when `cke` is high and SELF REFRESH entry (8) when `cke` is low. The code appears on `cmd_code` after the next rising edge.
- R3: An ACTIVE to an idle bank opens that bank and stores row `addr[10:0]`. A READ or WRITE to an open bank reports that stored row on `cmd_row`, the column `addr[7:0]` on `cmd_col` and `addr[10]` on `cmd_ap`.
- R4: An ACTIVE to a bank that already has an open row is an error. The stored row stays unchanged.
- R5: A READ or WRITE to an idle bank is an error and changes no bank state.
- R6: A PRECHARGE with `addr[10]` low closes only bank `ba`. With `addr[10]` high it closes all banks, and `ba` has no effect.
- R7: A MODE LOAD captures `addr[9:0]` into `mode_reg`, but only when every bank is idle. Otherwise it is an error and `mode_reg` keeps its value.
- R8: For TMRD-1 edges after an accepted MODE LOAD (1 edge by default), any command other than inhibit or NOP is an error and is ignored.
- R9: A READ or WRITE with `addr[10]` high closes its bank exactly BL edges after the command edge. BL comes from `mode_reg[2:0]`: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and any other value gives 1.
- R10: `cmd_err` is high for exactly the one cycle after an offending command edge. It is low after a legal command.
- R11: `rd_dq_hiz` at a rising edge equals the `dqm` value sampled two rising edges earlier, lane by lane.
- R12: `wr_dq_mask` equals `dqm` in the same cycle, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable; picks auto or self refresh |
| ba | input | 2 | Bank select |
| addr | input | 11 | Row, column, flag and mode-word address bits |
| dqm | input | 4 | Per-lane data mask |
| cmd_code | output | 4 | Registered decoded command code |
| cmd_bank | output | 2 | Bank of the reported command |
| cmd_row | output | 11 | Row opened, or row accessed |
| cmd_col | output | 8 | Column of a READ or WRITE |
| cmd_ap | output | 1 | Auto-precharge / all-banks flag |
| cmd_err | output | 1 | One-cycle protocol violation pulse |
| bank_open | output | 4 | Open flag per bank |
| mode_reg | output | 10 | Captured mode word |
| rd_dq_hiz | output | 4 | Read-side lane mask, two-edge delay |
| wr_dq_mask | output | 4 | Write-side lane mask, no delay |

## Verification
Some rules are checked on every cycle by the assertions. An ACTIVE to an open bank, a READ or WRITE to an idle bank, and an executable command inside the mode-load window must each raise the error flag. The mode word may change only after an accepted load with all banks idle. A precharge must close the banks it addresses. The read mask must trail `dqm` by two edges.

Other behaviour needs the directed scenarios, because only a sequence of commands shows it. Those scenarios check that a rejected ACTIVE keeps the old row and that the auto-precharge countdown closes the bank on the right edge for two burst lengths. They also check the full decode table, including the refresh split on `cke`, and that the error flag drops on the next legal command.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

  typedef enum logic [3:0] {
    CMD_INH  = 4'd0,
    CMD_NOP  = 4'd1,
    CMD_ACT  = 4'd2,
    CMD_RD   = 4'd3,
    CMD_WR   = 4'd4,
    CMD_BST  = 4'd5,
    CMD_PRE  = 4'd6,
    CMD_AREF = 4'd7,
    CMD_SREF = 4'd8,
    CMD_LMR  = 4'd9
  } cmd_e;

  // Pin pattern to command; chip select dominates.
  function automatic cmd_e decode_pins(logic cs_n, logic ras_n, logic cas_n,
                                       logic we_n, logic cke);
    if (cs_n) return CMD_INH;
    case ({ras_n, cas_n, we_n})
      3'b111:  return CMD_NOP;
      3'b011:  return CMD_ACT;
      3'b101:  return CMD_RD;
      3'b100:  return CMD_WR;
      3'b110:  return CMD_BST;
      3'b010:  return CMD_PRE;
      3'b001:  return cke ? CMD_AREF : CMD_SREF;
      default: return CMD_LMR;
    endcase
  endfunction

  // Burst length code to beat count.
  function automatic logic [3:0] burst_beats(logic [2:0] code);
    case (code)
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
  import sdr_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  output cmd_e cmd,
  output logic is_exec
);
  always_comb begin
    cmd     = decode_pins(cs_n, ras_n, cas_n, we_n, cke);
    is_exec = (cmd != CMD_INH) && (cmd != CMD_NOP);
  end

  always_comb begin
    a_r1_inhibit_wins : assert (!cs_n || cmd == CMD_INH);
  end
endmodule

// File: rtl/sdr_bank_table.sv
module sdr_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 11,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            act_go,
  input  logic                            rw_go,
  input  logic                            rw_ap,
  input  logic                            pre_go,
  input  logic                            pre_all,
  input  logic [BANK_W-1:0]               sel,
  input  logic [ROW_W-1:0]                row_in,
  input  logic [3:0]                      beats,
  output logic [NUM_BANKS-1:0]            open_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0] rows_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             hit;
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [3:0]       ap_cnt_q;
    logic             ap_done;

    assign hit     = (sel == BANK_W'(b));
    assign ap_done = (ap_cnt_q == 4'd1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q   <= 1'b0;
        row_q    <= '0;
        ap_cnt_q <= '0;
      end else if (act_go && hit) begin
        open_q   <= 1'b1;
        row_q    <= row_in;
        ap_cnt_q <= '0;
      end else if (pre_go && (pre_all || hit)) begin
        open_q   <= 1'b0;
        ap_cnt_q <= '0;
      end else if (rw_go && hit) begin
        ap_cnt_q <= rw_ap ? beats : 4'd0;
      end else if (ap_done) begin
        open_q   <= 1'b0;
        ap_cnt_q <= '0;
      end else if (ap_cnt_q != 4'd0) begin
        ap_cnt_q <= ap_cnt_q - 4'd1;
      end
    end

    assign open_o[b] = open_q;
    assign rows_o[b] = row_q;

    a_r6_pre_closes : assert property (@(posedge clk) disable iff (!rst_n)
      (pre_go && (pre_all || hit)) |=> !open_q);
    a_r9_ap_closes : assert property (@(posedge clk) disable iff (!rst_n)
      (ap_done && !(act_go && hit) && !(rw_go && hit)) |=> !open_q);
  end
endmodule

// File: rtl/sdr_dqm_path.sv
module sdr_dqm_path #(
  parameter int LANES  = 4,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] dqm,
  output logic [LANES-1:0] rd_hiz,
  output logic [LANES-1:0] wr_mask
);
  logic [RD_LAT-1:0][LANES-1:0] pipe_q;

  for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pipe_q[s] <= '0;
      else if (s == 0) pipe_q[s] <= dqm;
      else             pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign rd_hiz  = pipe_q[RD_LAT-1];
  assign wr_mask = dqm;

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                warm_q <= '0;
    else if (warm_q != 2'd2)   warm_q <= warm_q + 2'd1;
  end

  if (RD_LAT == 2) begin : g_chk
    a_r11_rd_delay : assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd2) |-> (rd_hiz == $past(dqm, 2)));
  end
  always_comb begin
    a_r12_wr_direct : assert (wr_mask == dqm);
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdr_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int ADDR_W    = 11,
  parameter int MODE_W    = 10,
  parameter int DQM_W     = 4,
  parameter int TMRD      = 2,
  parameter int RD_LAT    = 2,
  parameter int AP_BIT    = 10,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int MRD_W    = $clog2(TMRD + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic                 cke,
  input  logic [BANK_W-1:0]    ba,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DQM_W-1:0]     dqm,
  output logic [3:0]           cmd_code,
  output logic [BANK_W-1:0]    cmd_bank,
  output logic [ROW_W-1:0]     cmd_row,
  output logic [COL_W-1:0]     cmd_col,
  output logic                 cmd_ap,
  output logic                 cmd_err,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [MODE_W-1:0]    mode_reg,
  output logic [DQM_W-1:0]     rd_dq_hiz,
  output logic [DQM_W-1:0]     wr_dq_mask
);
  cmd_e cmd;
  logic is_exec;

  sdr_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
    .cmd(cmd), .is_exec(is_exec)
  );

  // Named legality events
  logic is_rw, mrd_busy, mrd_viol, act_viol, rw_viol, lmr_viol, viol;
  logic act_go, rw_go, pre_go, lmr_go;
  logic [MRD_W-1:0]  mrd_cnt_q;
  logic [MODE_W-1:0] mode_q;
  logic [NUM_BANKS-1:0][ROW_W-1:0] rows;

  assign is_rw    = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign mrd_busy = (mrd_cnt_q != '0);
  assign mrd_viol = mrd_busy && is_exec;
  assign act_viol = (cmd == CMD_ACT) && bank_open[ba];
  assign rw_viol  = is_rw && !bank_open[ba];
  assign lmr_viol = (cmd == CMD_LMR) && (|bank_open);
  assign viol     = mrd_viol || act_viol || rw_viol || lmr_viol;
  assign act_go   = (cmd == CMD_ACT) && !viol;
  assign rw_go    = is_rw && !viol;
  assign pre_go   = (cmd == CMD_PRE) && !viol;
  assign lmr_go   = (cmd == CMD_LMR) && !viol;

  sdr_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .act_go(act_go), .rw_go(rw_go), .rw_ap(addr[AP_BIT]),
    .pre_go(pre_go), .pre_all(addr[AP_BIT]),
    .sel(ba), .row_in(addr[ROW_W-1:0]),
    .beats(burst_beats(mode_q[2:0])),
    .open_o(bank_open), .rows_o(rows)
  );

  sdr_dqm_path #(.LANES(DQM_W), .RD_LAT(RD_LAT)) u_dqm (
    .clk(clk), .rst_n(rst_n), .dqm(dqm),
    .rd_hiz(rd_dq_hiz), .wr_mask(wr_dq_mask)
  );

  // Mode word and its settle window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      mrd_cnt_q <= '0;
    end else if (lmr_go) begin
      mode_q    <= addr[MODE_W-1:0];
      mrd_cnt_q <= MRD_W'(TMRD - 1);
    end else if (mrd_busy) begin
      mrd_cnt_q <= mrd_cnt_q - 1'b1;
    end
  end
  assign mode_reg = mode_q;

  // Registered command report
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_code <= 4'(CMD_INH);
      cmd_bank <= '0;
      cmd_row  <= '0;
      cmd_col  <= '0;
      cmd_ap   <= 1'b0;
      cmd_err  <= 1'b0;
    end else begin
      cmd_code <= 4'(cmd);
      cmd_bank <= (is_rw || cmd == CMD_ACT || cmd == CMD_PRE) ? ba : '0;
      if (cmd == CMD_ACT)                 cmd_row <= addr[ROW_W-1:0];
      else if (is_rw && bank_open[ba])    cmd_row <= rows[ba];
      else                                cmd_row <= '0;
      cmd_col  <= is_rw ? addr[COL_W-1:0] : '0;
      cmd_ap   <= (is_rw || cmd == CMD_PRE) ? addr[AP_BIT] : 1'b0;
      cmd_err  <= viol;
    end
  end

  a_r3_act_opens : assert property (@(posedge clk) disable iff (!rst_n)
    act_go |=> bank_open[$past(ba)]);
  a_r4_act_twice : assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT && bank_open[ba]) |=> cmd_err);
  a_r5_rw_idle : assert property (@(posedge clk) disable iff (!rst_n)
    (is_rw && !bank_open[ba]) |=> (cmd_err && $stable(bank_open)));
  a_r7_mode_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_reg) |-> $past(cmd == CMD_LMR && bank_open == '0));
  a_r8_mrd_block : assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_busy && is_exec) |=> cmd_err);
  a_r10_err_source : assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(viol));
endmodule

// File: tb/sdram_cmd_tracker_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0]  ba = '0;
  logic [10:0] addr = '0;
  logic [3:0]  dqm = '0;
  logic [3:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [10:0] cmd_row;
  logic [7:0]  cmd_col;
  logic        cmd_ap, cmd_err;
  logic [3:0]  bank_open;
  logic [9:0]  mode_reg;
  logic [3:0]  rd_dq_hiz, wr_dq_mask;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_cmd_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .dqm(dqm),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .cmd_ap(cmd_ap), .cmd_err(cmd_err),
    .bank_open(bank_open), .mode_reg(mode_reg),
    .rd_dq_hiz(rd_dq_hiz), .wr_dq_mask(wr_dq_mask)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one command for one edge (called at a negedge), then NOP.
  task automatic issue(logic c, logic r, logic a, logic w, logic [1:0] b,
                       logic [10:0] ad);
    cs_n = c; ras_n = r; cas_n = a; we_n = w; ba = b; addr = ad;
    @(negedge clk);
    cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; ba = '0; addr = '0;
  endtask
  task automatic nop();            issue(0,1,1,1,2'd0,11'd0);        endtask
  task automatic act(logic [1:0] b, logic [10:0] row); issue(0,0,1,1,b,row); endtask
  task automatic rd(logic [1:0] b, logic ap, logic [7:0] col);
    issue(0,1,0,1,b,{ap,2'b00,col});
  endtask
  task automatic wr(logic [1:0] b, logic ap, logic [7:0] col);
    issue(0,1,0,0,b,{ap,2'b00,col});
  endtask
  task automatic pre(logic [1:0] b, logic all); issue(0,0,1,0,b,{all,10'd0}); endtask
  task automatic lmr(logic [9:0] m); issue(0,0,0,0,2'd0,{1'b0,m}); endtask

  task automatic t_reset();
    chk("R1 reset code", cmd_code, 0);
    chk("R10 reset err", cmd_err, 0);
    chk("R3 reset banks", bank_open, 0);
    chk("R7 reset mode", mode_reg, 0);
  endtask

  task automatic t_decode();
    issue(1,0,0,0,2'd0,11'd0);
    chk("R1 inhibit code", cmd_code, 0);
    chk("R1 inhibit no err", cmd_err, 0);
    nop();                 chk("R2 nop", cmd_code, 1);
    issue(0,1,1,0,2'd0,0); chk("R2 burst stop", cmd_code, 5);
    issue(0,0,0,1,2'd0,0); chk("R2 auto refresh", cmd_code, 7);
    cke = 1'b0;
    issue(0,0,0,1,2'd0,0); chk("R2 self refresh", cmd_code, 8);
    cke = 1'b1;
  endtask

  task automatic t_mode_load();
    lmr(10'h032);
    chk("R2 mode load code", cmd_code, 9);
    chk("R7 mode captured", mode_reg, 10'h032);
    chk("R7 legal no err", cmd_err, 0);
    act(2'd0, 11'd1);
    chk("R8 window err", cmd_err, 1);
    chk("R8 window ignored", bank_open, 4'b0000);
    nop();
    chk("R10 err cleared", cmd_err, 0);
    act(2'd0, 11'd1);
    chk("R8 after window ok", cmd_err, 0);
    chk("R3 bank0 open", bank_open, 4'b0001);
  endtask

  task automatic t_activate();
    act(2'd1, 11'h5A3);
    chk("R2 act code", cmd_code, 2);
    chk("R3 act row", cmd_row, 11'h5A3);
    chk("R3 bank1 open", bank_open, 4'b0011);
    act(2'd1, 11'h111);
    chk("R4 reopen err", cmd_err, 1);
    rd(2'd1, 1'b0, 8'h44);
    chk("R2 read code", cmd_code, 3);
    chk("R4 row kept", cmd_row, 11'h5A3);
    chk("R3 read col", cmd_col, 8'h44);
    chk("R3 read ap", cmd_ap, 0);
    chk("R10 read no err", cmd_err, 0);
    chk("R3 bank1 stays", bank_open, 4'b0011);
  endtask

  task automatic t_idle_access();
    wr(2'd2, 1'b0, 8'h10);
    chk("R2 write code", cmd_code, 4);
    chk("R5 idle write err", cmd_err, 1);
    chk("R5 banks unchanged", bank_open, 4'b0011);
    rd(2'd3, 1'b1, 8'h00);
    chk("R5 idle read err", cmd_err, 1);
    chk("R5 banks unchanged 2", bank_open, 4'b0011);
  endtask

  task automatic t_mode_busy();
    lmr(10'h3FF);
    chk("R7 busy err", cmd_err, 1);
    chk("R7 mode kept", mode_reg, 10'h032);
  endtask

  task automatic t_precharge();
    pre(2'd1, 1'b0);
    chk("R2 pre code", cmd_code, 6);
    chk("R6 single close", bank_open, 4'b0001);
    act(2'd3, 11'h007);
    chk("R3 bank3 open", bank_open, 4'b1001);
    pre(2'd1, 1'b1);
    chk("R6 all close", bank_open, 4'b0000);
    chk("R6 all flag", cmd_ap, 1);
  endtask

  task automatic t_auto_pre();
    act(2'd2, 11'h020);
    wr(2'd2, 1'b1, 8'h03);
    chk("R3 write ap", cmd_ap, 1);
    chk("R9 open after cmd", bank_open, 4'b0100);
    nop(); nop(); nop();
    chk("R9 open at BL-1", bank_open, 4'b0100);
    nop();
    chk("R9 closed at BL4", bank_open, 4'b0000);
    lmr(10'h030);
    chk("R7 mode BL1", mode_reg, 10'h030);
    nop();
    act(2'd0, 11'h0AA);
    rd(2'd0, 1'b1, 8'h01);
    chk("R9 open after read", bank_open, 4'b0001);
    nop();
    chk("R9 closed at BL1", bank_open, 4'b0000);
  endtask

  task automatic t_dqm();
    logic [3:0] vals [5] = '{4'h3, 4'hC, 4'h5, 4'hF, 4'h0};
    dqm = 4'hA;
    #1 chk("R12 write mask now", wr_dq_mask, 4'hA);
    for (int i = 0; i < 5; i++) begin
      dqm = vals[i];
      #0.5 chk("R12 write mask", wr_dq_mask, vals[i]);
      @(negedge clk);
      if (i >= 1) chk("R11 read mask delay", rd_dq_hiz, vals[i-1]);
    end
    dqm = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_mode_load();
    t_activate();
    t_idle_access();
    t_mode_busy();
    t_precharge();
    t_auto_pre();
    t_dqm();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule